// File: doc/BRIEF.md
# Scaling-Free Pipelined CORDIC Rotator

This block turns a signed fixed-point vector (x, y) by an unsigned angle, using only shifts and additions. The angle's two top bits pick a quadrant. Each of the remaining bits directly switches one shift-add stage on or off, so the block makes no sign decisions and has no recoding step.

Every active stage turns the vector anticlockwise by an elementary angle of 2^-k radian. The stage's cosine and sine are taken as truncated base-2 series, 1 - 2^-(2k+1) and 2^-k. The product of these stage factors stays close to one, so no gain-correction multiply follows the stages. A small constant is added to x and y on entry to offset the downward bias of the truncating shifts. The quadrant is applied at the output as a swap and negation of the rotated pair. The result is then rounded down to the input width and saturated.

The pipeline takes one input per clock and has a fixed latency. A valid flag travels with the data, and there is no back-pressure.

Top module: `sf_cordic_rotator`

## Requirements
- R1: While rst is high and on the first edge after it falls, out_valid, out_x and out_y read 0.
- R2: in_angle[N-1:0] is the in-quadrant angle. Bit N-k (k = 1..N, MSB first) enables stage k, whose weight is 2^-k radian. A clear bit leaves that stage's x and y unchanged.
- R3: An enabled stage k computes x' = x - (x >>> (2k+1)) - (y >>> k) and y' = y - (y >>> (2k+1)) + (x >>> k). Here >>> is an arithmetic (floor) shift on the internal two's-complement value.
- R4: On entry, x and y are sign-extended, multiplied by 2^GUARD (GUARD = 2), and each increased by INIT_OFS internal LSBs (default 2).
- R5: The quadrant field in_angle[N+1:N] maps the rotated pair (xr, yr) to the output as follows: 0 gives (xr, yr), 1 gives (-yr, xr), 2 gives (-xr, -yr), 3 gives (yr, -xr).
- R6: out_valid repeats in_valid delayed by N+2 clock edges. The data on out_x and out_y belongs to the same input as that valid.
- R7: Each output is the folded value shifted right (floor) by GUARD bits and then saturated to the signed range of IN_W bits.
- R8: No gain correction is applied. An angle of zero returns the input vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_angle | input | N+2 | Unsigned angle: quadrant in the top 2 bits, stage enables below |
| in_x | input | IN_W | Input x, two's complement |
| in_y | input | IN_W | Input y, two's complement |
| out_valid | output | 1 | Output sample present |
| out_x | output | IN_W | Rotated x, saturated |
| out_y | output | IN_W | Rotated y, saturated |

## Verification
The assertions assume that in_valid and in_angle are never unknown after reset. They also assume that the internal width leaves enough headroom for any IN_W-bit input vector, so no stage wraps. The stimulus keeps to legal IN_W-bit values, including the most negative corner pair, which drives the output saturation.

The stimulus covers every angle code for a fixed vector, for the corner vector and for the zero vector. It then runs pseudo-random vectors and angles with gaps in in_valid, so that the valid flag is seen to travel with its data.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    Q_FIRST  = 2'd0,
    Q_SECOND = 2'd1,
    Q_THIRD  = 2'd2,
    Q_FOURTH = 2'd3
  } quad_e;
endpackage

// File: rtl/sfc_prep.sv
module sfc_prep
  import sfc_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int N        = 8,
  parameter int GUARD    = 2,
  parameter int W        = 16,
  parameter int INIT_OFS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic [N+1:0]        ang_i,
  input  logic [IN_W-1:0]     x_i,
  input  logic [IN_W-1:0]     y_i,
  output logic                v_o,
  output logic [N-1:0]        ang_o,
  output quad_e               q_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [W-1:0] OFS = W'(INIT_OFS);

  logic signed [W-1:0] xe, ye;

  always_comb begin
    xe = (W'($signed(x_i)) <<< GUARD) + OFS;
    ye = (W'($signed(y_i)) <<< GUARD) + OFS;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    x_o   <= xe;
    y_o   <= ye;
    ang_o <= ang_i[N-1:0];
    q_o   <= quad_e'(ang_i[N+1:N]);
  end

  assert_prep_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/sfc_stage.sv
module sfc_stage
  import sfc_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 8,
  parameter int K = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic [N-1:0]        ang_i,
  input  quad_e               q_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic                v_o,
  output logic [N-1:0]        ang_o,
  output quad_e               q_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  localparam int SH_COS = 2 * K + 1;
  localparam int SH_SIN = K;
  localparam int SEL    = N - K;

  logic                en;
  logic signed [W-1:0] xn, yn;

  always_comb begin
    en = ang_i[SEL];
    if (en) begin
      xn = x_i - (x_i >>> SH_COS) - (y_i >>> SH_SIN);
      yn = y_i - (y_i >>> SH_COS) + (x_i >>> SH_SIN);
    end else begin
      xn = x_i;
      yn = y_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    x_o   <= xn;
    y_o   <= yn;
    ang_o <= ang_i;
    q_o   <= q_i;
  end

  assert_stage_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_o == $past(v_i)));

  assert_stage_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(v_i) && !ang_o[SEL]) |->
      (x_o == $past(x_i) && y_o == $past(y_i)));

  assert_stage_quad_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q_o == $past(q_i)));
endmodule

// File: rtl/sfc_out.sv
module sfc_out
  import sfc_pkg::*;
#(
  parameter int W     = 16,
  parameter int OUT_W = 12,
  parameter int GUARD = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  quad_e               q_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic                v_o,
  output logic [OUT_W-1:0]    x_o,
  output logic [OUT_W-1:0]    y_o
);
  localparam logic signed [W-1:0] HI = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [W-1:0] LO = -HI - W'(1);

  logic signed [W-1:0] fx, fy, sx, sy;
  logic [OUT_W-1:0]    ox, oy;

  always_comb begin
    unique case (q_i)
      Q_FIRST:  begin fx = x_i;  fy = y_i;  end
      Q_SECOND: begin fx = -y_i; fy = x_i;  end
      Q_THIRD:  begin fx = -x_i; fy = -y_i; end
      default:  begin fx = y_i;  fy = -x_i; end
    endcase
    sx = fx >>> GUARD;
    sy = fy >>> GUARD;
    ox = (sx > HI) ? OUT_W'(HI) : (sx < LO) ? OUT_W'(LO) : OUT_W'(sx);
    oy = (sy > HI) ? OUT_W'(HI) : (sy < LO) ? OUT_W'(LO) : OUT_W'(sy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
    end else begin
      v_o <= v_i;
      x_o <= ox;
      y_o <= oy;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!v_o && x_o == '0 && y_o == '0));

  assert_out_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/sf_cordic_rotator.sv
module sf_cordic_rotator
  import sfc_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int N        = 8,
  parameter int GUARD    = 2,
  parameter int HEAD     = 2,
  parameter int INIT_OFS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [N+1:0]    in_angle,
  input  logic [IN_W-1:0] in_x,
  input  logic [IN_W-1:0] in_y,
  output logic            out_valid,
  output logic [IN_W-1:0] out_x,
  output logic [IN_W-1:0] out_y
);
  localparam int W = IN_W + GUARD + HEAD;

  logic                pv   [0:N];
  logic [N-1:0]        pang [0:N];
  quad_e               pq   [0:N];
  logic signed [W-1:0] px   [0:N];
  logic signed [W-1:0] py   [0:N];

  sfc_prep #(
    .IN_W(IN_W), .N(N), .GUARD(GUARD), .W(W), .INIT_OFS(INIT_OFS)
  ) u_prep (
    .clk(clk), .rst(rst), .v_i(in_valid), .ang_i(in_angle),
    .x_i(in_x), .y_i(in_y),
    .v_o(pv[0]), .ang_o(pang[0]), .q_o(pq[0]), .x_o(px[0]), .y_o(py[0])
  );

  for (genvar g = 1; g <= N; g++) begin : g_stage
    sfc_stage #(.W(W), .N(N), .K(g)) u_stage (
      .clk(clk), .rst(rst),
      .v_i(pv[g-1]), .ang_i(pang[g-1]), .q_i(pq[g-1]),
      .x_i(px[g-1]), .y_i(py[g-1]),
      .v_o(pv[g]), .ang_o(pang[g]), .q_o(pq[g]),
      .x_o(px[g]), .y_o(py[g])
    );
  end

  sfc_out #(.W(W), .OUT_W(IN_W), .GUARD(GUARD)) u_out (
    .clk(clk), .rst(rst), .v_i(pv[N]), .q_i(pq[N]),
    .x_i(px[N]), .y_i(py[N]),
    .v_o(out_valid), .x_o(out_x), .y_o(out_y)
  );
endmodule

// File: tb/sf_cordic_rotator_bench.sv
module sf_cordic_rotator_bench;
  localparam int CLK_P = 10;
  localparam int IN_W  = 12;
  localparam int N     = 8;
  localparam int GUARD = 2;
  localparam int OFS   = 2;
  localparam int LAT   = N + 2;
  localparam int DEPTH = 64;
  localparam int NANG  = 1 << (N + 2);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [N+1:0]    in_angle = '0;
  logic [IN_W-1:0] in_x = '0;
  logic [IN_W-1:0] in_y = '0;
  logic            out_valid;
  logic [IN_W-1:0] out_x, out_y;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit          bv [DEPTH];
  logic [IN_W-1:0] bx [DEPTH];
  logic [IN_W-1:0] by [DEPTH];
  string       bt [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  sf_cordic_rotator #(.IN_W(IN_W), .N(N), .GUARD(GUARD), .INIT_OFS(OFS)) u_sf_cordic_rotator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
    .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  function automatic longint sat(longint v);
    longint hi = (64'sd1 <<< (IN_W - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  // Model built from R2, R3, R4, R5, R7
  task automatic model(input logic [N+1:0] a, input logic [IN_W-1:0] xi,
                       input logic [IN_W-1:0] yi, output logic [IN_W-1:0] ex,
                       output logic [IN_W-1:0] ey, output string tag);
    longint x, y, nx, ny, fx, fy, rx, ry;
    bit clipped;
    x = longint'($signed(xi)) * (1 << GUARD) + OFS;
    y = longint'($signed(yi)) * (1 << GUARD) + OFS;
    for (int k = 1; k <= N; k++) begin
      if (a[N-k]) begin
        nx = x - (x >>> (2*k+1)) - (y >>> k);
        ny = y - (y >>> (2*k+1)) + (x >>> k);
        x = nx; y = ny;
      end
    end
    case (a[N+1:N])
      2'd0: begin fx = x;  fy = y;  end
      2'd1: begin fx = -y; fy = x;  end
      2'd2: begin fx = -x; fy = -y; end
      default: begin fx = y; fy = -x; end
    endcase
    fx = fx >>> GUARD;
    fy = fy >>> GUARD;
    rx = sat(fx);
    ry = sat(fy);
    clipped = (rx != fx) || (ry != fy);
    ex = IN_W'(rx);
    ey = IN_W'(ry);
    if (xi == '0 && yi == '0)               tag = "R4";
    else if (a == '0)                       tag = "R8";
    else if (clipped)                       tag = "R7";
    else if (a[N+1:N] != 2'd0)              tag = "R5";
    else if ($countones(a[N-1:0]) == 1)     tag = "R2";
    else                                    tag = "R3";
  endtask

  task automatic check_out();
    int idx;
    checks++;
    if (cyc < LAT) begin
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R6 early valid: got %b expected 0", out_valid);
      end
    end else begin
      idx = (cyc - LAT) % DEPTH;
      if (out_valid !== bv[idx]) begin
        errors++;
        $display("FAIL R6 valid at cycle %0d: got %b expected %b", cyc, out_valid, bv[idx]);
      end else if (bv[idx]) begin
        checks++;
        if (out_x !== bx[idx] || out_y !== by[idx]) begin
          errors++;
          $display("FAIL %s data: got (%0d,%0d) expected (%0d,%0d)", bt[idx],
                   $signed(out_x), $signed(out_y), $signed(bx[idx]), $signed(by[idx]));
        end
      end
    end
  endtask

  task automatic step(input bit v, input logic [N+1:0] a,
                      input logic [IN_W-1:0] xi, input logic [IN_W-1:0] yi);
    logic [IN_W-1:0] ex, ey;
    string tg;
    @(negedge clk);
    check_out();
    in_valid = v; in_angle = a; in_x = xi; in_y = yi;
    model(a, xi, yi, ex, ey, tg);
    bv[cyc % DEPTH] = v;
    bx[cyc % DEPTH] = ex;
    by[cyc % DEPTH] = ey;
    bt[cyc % DEPTH] = tg;
    cyc++;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    for (int i = 0; i < DEPTH; i++) bv[i] = 1'b0;
    in_valid = 1'b1;
    in_x = 12'd5;
    in_y = 12'd7;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_x !== '0 || out_y !== '0) begin
        errors++;
        $display("FAIL R1 reset state: got (%b,%0d,%0d) expected (0,0,0)",
                 out_valid, out_x, out_y);
      end
    end
    in_valid = 1'b0;
    rst = 1'b0;
    for (int a = 0; a < NANG; a++) step(1'b1, (N+2)'(a), 12'd1500, -12'sd700);
    for (int a = 0; a < NANG; a++) step(1'b1, (N+2)'(a), 12'h800, 12'h800);
    for (int a = 0; a < NANG; a++) step(1'b1, (N+2)'(a), 12'd0, 12'd0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] != 2'b00, (N+2)'(lfsr ^ (lfsr >> 7)),
           IN_W'(lfsr * 3), IN_W'(lfsr ^ 16'h5A3C));
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule